// File: doc/BRIEF.md
# Framed Serial Register-Write Decoder

This block sits behind a byte-wide receiver on a host serial link and turns the
incoming byte stream into register writes. A frame opens with a fixed run of
five sync bytes. It then carries any number of 16-bit command words, each sent
most significant byte first. A single closing byte ends the frame. Every
command word packs a 4-bit register address and an 8-bit data value into a
scattered layout. The layout holds inverted copies of two data bits, so each
word can be checked on its own.

For every word that passes the check, the decoder issues one single-cycle write
strobe with its address and data, in the order the words arrived. A word that
fails the check produces no write and sets a sticky error flag. One address is
reserved as a bank-select register. Writing it with the alternate bank code moves
later writes into the alternate register bank, and the decoder tags those writes
with a bank indicator. The byte-valid qualifier lets the receiver leave idle
gaps between bytes at any point.

Top module: `cmdlink_decoder`

## Requirements
- R1: While reset is held and in the first cycle after it, wr_stb and chk_err are 0, and the first valid writes report wr_alt_bank = 0.
- R2: No write is issued for bytes received before a complete sync sequence 0x40, 0x4C, 0x44, 0x53, 0x7E.
- R3: A byte that breaks the sync sequence restarts the search. If that byte is itself 0x40, it counts as the first sync byte, so 0x40 0x4C 0x40 0x4C 0x44 0x53 0x7E opens a frame.
- R4: For a word w sent as w[15:8] then w[7:0], the write carries wr_addr = w[11:8] and wr_data = {w[13:12], w[5:0]}. wr_stb is high for exactly the one cycle after the clock edge that samples the low byte.
- R5: A word with w[15] = 1, w[7] = 1, w[6] = w[5] or w[14] = w[13] produces no write. It raises chk_err one cycle after its low byte, and chk_err stays 1 until reset.
- R6: Several words in one frame produce separate writes in arrival order, including repeated writes to the same address.
- R7: The byte 0x7E in a high-byte position closes the frame, and an empty frame is legal. Bytes after the close produce no writes until a new sync sequence.
- R8: A valid write to address 15 with data[5:4] = 2 selects the alternate bank, and a write to address 15 with any other data[5:4] selects the default bank. Each write reports in wr_alt_bank the bank in force before that write, so the bank-select write itself carries the old bank.
- R9: Bytes presented with rx_valid = 0 are ignored at any point of a frame.
- R10: The selected bank is kept across frame boundaries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | rx_byte holds a received byte this cycle |
| rx_byte | input | 8 | Received byte |
| wr_stb | output | 1 | Single-cycle register write strobe |
| wr_addr | output | 4 | Register address of the write |
| wr_data | output | 8 | Data of the write |
| wr_alt_bank | output | 1 | Write is aimed at the alternate bank |
| chk_err | output | 1 | Sticky flag: a word failed the check |

## Verification
Every result of this block comes out one clock after the edge that samples the
low byte of a word: the strobe, its address and data, the bank tag and the error
flag. Nothing moves on a high byte or a sync byte. The bench drives one byte per
cycle, or an idle cycle, and updates a behavioural model with that byte. One
time unit after the following rising edge, it compares the outputs with the
model's expected values, so each comparison falls in the cycle where the result
is due. Per-scenario strobe counts also confirm that ignored bytes produced no
writes.

// File: rtl/cmdlink_pkg.sv
package cmdlink_pkg;
  localparam int BYTE_W = 8;
  localparam int WORD_W = 2 * BYTE_W;
  localparam int ADDR_W = 4;
  localparam int DATA_W = 8;

  typedef enum logic [1:0] {
    FR_PRE = 2'd0,
    FR_HI  = 2'd1,
    FR_LO  = 2'd2
  } fr_state_e;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
  } wr_cmd_t;
endpackage

// File: rtl/cmdlink_framer.sv
module cmdlink_framer
  import cmdlink_pkg::*;
#(
  parameter int PRE_LEN = 5,
  parameter logic [PRE_LEN*BYTE_W-1:0] PREAMBLE = 40'h40_4C_44_53_7E,
  parameter logic [BYTE_W-1:0] TERM = 8'h7E
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_valid,
  input  logic [BYTE_W-1:0] rx_byte,
  output logic              word_vld,
  output logic [WORD_W-1:0] word
);
  localparam int IDX_W = (PRE_LEN > 1) ? $clog2(PRE_LEN) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(PRE_LEN - 1);
  localparam logic [IDX_W-1:0] SECOND_IDX = IDX_W'(1);

  logic [BYTE_W-1:0] pre_bytes [PRE_LEN];
  fr_state_e         state_q;
  logic [IDX_W-1:0]  pre_idx_q;
  logic [BYTE_W-1:0] hi_q;

  // sync bytes, first one in the top byte of PREAMBLE
  for (genvar g = 0; g < PRE_LEN; g++) begin : g_pre
    assign pre_bytes[g] = PREAMBLE[(PRE_LEN-1-g)*BYTE_W +: BYTE_W];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= FR_PRE;
      pre_idx_q <= '0;
      hi_q      <= '0;
    end else if (rx_valid) begin
      case (state_q)
        FR_PRE: begin
          if (rx_byte == pre_bytes[pre_idx_q]) begin
            if (pre_idx_q == LAST_IDX) begin
              state_q   <= FR_HI;
              pre_idx_q <= '0;
            end else begin
              pre_idx_q <= pre_idx_q + 1'b1;
            end
          end else if (rx_byte == pre_bytes[0]) begin
            pre_idx_q <= SECOND_IDX;
          end else begin
            pre_idx_q <= '0;
          end
        end
        FR_HI: begin
          if (rx_byte == TERM) begin
            state_q <= FR_PRE;
          end else begin
            hi_q    <= rx_byte;
            state_q <= FR_LO;
          end
        end
        FR_LO:   state_q <= FR_HI;
        default: state_q <= FR_PRE;
      endcase
    end
  end

  assign word_vld = rx_valid && (state_q == FR_LO);
  assign word     = {hi_q, rx_byte};
endmodule

// File: rtl/cmdlink_word_check.sv
module cmdlink_word_check
  import cmdlink_pkg::*;
(
  input  logic [WORD_W-1:0] word,
  output logic              word_ok,
  output wr_cmd_t           cmd
);
  logic zero_ok;
  logic inv_lo_ok;
  logic inv_hi_ok;

  always_comb begin
    zero_ok   = !word[15] && !word[7];
    inv_lo_ok = word[6] != word[5];
    inv_hi_ok = word[14] != word[13];
    word_ok   = zero_ok && inv_lo_ok && inv_hi_ok;
    cmd.addr  = word[11:8];
    cmd.data  = {word[13:12], word[5:0]};
  end
endmodule

// File: rtl/cmdlink_writer.sv
module cmdlink_writer
  import cmdlink_pkg::*;
#(
  parameter logic [ADDR_W-1:0] BANK_REG = 4'hF,
  parameter int BANK_LSB = 4,
  parameter int BANK_W = 2,
  parameter int ALT_CODE = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              word_vld,
  input  logic              word_ok,
  input  wr_cmd_t           cmd,
  output logic              wr_stb,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              wr_alt_bank,
  output logic              chk_err
);
  localparam logic [BANK_W-1:0] ALT_VAL = BANK_W'(ALT_CODE);

  logic alt_q;
  logic accept;
  logic reject;

  assign accept = word_vld && word_ok;
  assign reject = word_vld && !word_ok;

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_stb      <= 1'b0;
      wr_addr     <= '0;
      wr_data     <= '0;
      wr_alt_bank <= 1'b0;
      chk_err     <= 1'b0;
      alt_q       <= 1'b0;
    end else begin
      wr_stb <= accept;
      if (accept) begin
        wr_addr     <= cmd.addr;
        wr_data     <= cmd.data;
        wr_alt_bank <= alt_q;
        if (cmd.addr == BANK_REG) begin
          alt_q <= (cmd.data[BANK_LSB +: BANK_W] == ALT_VAL);
        end
      end
      if (reject) begin
        chk_err <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/cmdlink_decoder.sv
module cmdlink_decoder
  import cmdlink_pkg::*;
#(
  parameter int PRE_LEN = 5,
  parameter logic [PRE_LEN*BYTE_W-1:0] PREAMBLE = 40'h40_4C_44_53_7E,
  parameter logic [BYTE_W-1:0] TERM = 8'h7E,
  parameter logic [ADDR_W-1:0] BANK_REG = 4'hF,
  parameter int BANK_LSB = 4,
  parameter int BANK_W = 2,
  parameter int ALT_CODE = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_valid,
  input  logic [BYTE_W-1:0] rx_byte,
  output logic              wr_stb,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              wr_alt_bank,
  output logic              chk_err
);
  logic              word_vld;
  logic [WORD_W-1:0] word;
  logic              word_ok;
  wr_cmd_t           cmd;

  cmdlink_framer #(
    .PRE_LEN (PRE_LEN),
    .PREAMBLE(PREAMBLE),
    .TERM    (TERM)
  ) framer_i (
    .clk     (clk),
    .rst     (rst),
    .rx_valid(rx_valid),
    .rx_byte (rx_byte),
    .word_vld(word_vld),
    .word    (word)
  );

  cmdlink_word_check check_i (
    .word   (word),
    .word_ok(word_ok),
    .cmd    (cmd)
  );

  cmdlink_writer #(
    .BANK_REG(BANK_REG),
    .BANK_LSB(BANK_LSB),
    .BANK_W  (BANK_W),
    .ALT_CODE(ALT_CODE)
  ) writer_i (
    .clk        (clk),
    .rst        (rst),
    .word_vld   (word_vld),
    .word_ok    (word_ok),
    .cmd        (cmd),
    .wr_stb     (wr_stb),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .wr_alt_bank(wr_alt_bank),
    .chk_err    (chk_err)
  );
endmodule

// File: rtl/cmdlink_decoder_chk.sv
module cmdlink_decoder_chk (
  input logic clk,
  input logic rst,
  input logic rx_valid,
  input logic wr_stb,
  input logic wr_alt_bank,
  input logic chk_err
);
  // R4
  stb_after_byte_chk: assert property (@(posedge clk) disable iff (rst)
    wr_stb |-> $past(rx_valid));

  // R6
  stb_single_chk: assert property (@(posedge clk) disable iff (rst)
    wr_stb |=> !wr_stb);

  // R5
  err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    chk_err |=> chk_err);

  // R5
  err_no_write_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(chk_err) |-> !wr_stb);

  // R8
  bank_tag_moves_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(wr_alt_bank) |-> wr_stb);
endmodule

bind cmdlink_decoder cmdlink_decoder_chk chk_i (
  .clk        (clk),
  .rst        (rst),
  .rx_valid   (rx_valid),
  .wr_stb     (wr_stb),
  .wr_alt_bank(wr_alt_bank),
  .chk_err    (chk_err)
);

// File: tb/cmdlink_decoder_tb_top.sv
`timescale 1ns/1ps
module cmdlink_decoder_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rx_valid = 1'b0;
  logic [7:0] rx_byte = 8'h00;
  logic       wr_stb;
  logic [3:0] wr_addr;
  logic [7:0] wr_data;
  logic       wr_alt_bank;
  logic       chk_err;

  int n_chk = 0;
  int n_fail = 0;
  int n_stb = 0;
  string cur_req = "R1";

  // reference model state
  int         m_st = 0;
  int         m_idx = 0;
  logic [7:0] m_hi = 8'h00;
  logic       m_alt = 1'b0;
  logic       m_err = 1'b0;
  logic       e_stb = 1'b0;
  logic [3:0] e_addr = 4'h0;
  logic [7:0] e_data = 8'h00;
  logic       e_alt = 1'b0;
  byte unsigned sync_q[$] = '{8'h40, 8'h4C, 8'h44, 8'h53, 8'h7E};

  always #4 clk = ~clk;

  cmdlink_decoder dut_i (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data),
    .wr_alt_bank(wr_alt_bank), .chk_err(chk_err)
  );

  task automatic check(string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", cur_req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] mk(logic [3:0] a, logic [7:0] d);
    return {1'b0, ~d[7], d[7:6], a, 1'b0, ~d[5], d[5:0]};
  endfunction

  task automatic model(logic v, logic [7:0] b);
    logic [15:0] w;
    e_stb = 1'b0;
    if (!v) return;
    if (m_st == 0) begin
      if (b == sync_q[m_idx]) begin
        if (m_idx == sync_q.size() - 1) begin m_st = 1; m_idx = 0; end
        else m_idx++;
      end else m_idx = (b == 8'h40) ? 1 : 0;
    end else if (m_st == 1) begin
      if (b == 8'h7E) m_st = 0;
      else begin m_hi = b; m_st = 2; end
    end else begin
      w = {m_hi, b};
      m_st = 1;
      if (!w[15] && !w[7] && (w[6] == ~w[5]) && (w[14] == ~w[13])) begin
        e_stb = 1'b1; e_addr = w[11:8]; e_data = {w[13:12], w[5:0]}; e_alt = m_alt;
        if (e_addr == 4'hF) m_alt = (e_data[5:4] == 2'd2);
      end else m_err = 1'b1;
    end
  endtask

  task automatic step(logic v, logic [7:0] b);
    rx_valid = v;
    rx_byte = b;
    model(v, b);
    @(posedge clk);
    #1;
    check("wr_stb", wr_stb, e_stb);
    check("chk_err", chk_err, m_err);
    if (wr_stb) n_stb++;
    if (e_stb) begin
      check("wr_addr", wr_addr, e_addr);
      check("wr_data", wr_data, e_data);
      check("wr_alt_bank", wr_alt_bank, e_alt);
    end
  endtask

  task automatic put(logic [7:0] b); step(1'b1, b); endtask
  task automatic sync(); foreach (sync_q[i]) put(sync_q[i]); endtask
  task automatic wrd(logic [15:0] w); put(w[15:8]); put(w[7:0]); endtask

  initial begin
    repeat (30000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    cur_req = "R1";
    check("wr_stb in reset", wr_stb, 0);
    check("chk_err in reset", chk_err, 0);
    rst = 1'b0;
    step(1'b0, 8'h00);

    cur_req = "R2"; n_stb = 0;
    put(8'h11); put(8'h4C); put(8'h44); put(8'h53); put(8'h7E);
    wrd(mk(4'h2, 8'h33));
    check("strobes before sync", n_stb, 0);

    cur_req = "R4"; n_stb = 0;
    sync(); wrd(mk(4'h3, 8'hA5)); wrd(mk(4'hC, 8'h5A)); put(8'h7E);
    check("strobe count", n_stb, 2);

    cur_req = "R6"; n_stb = 0;
    sync(); wrd(mk(4'h1, 8'h01)); wrd(mk(4'h1, 8'h00)); wrd(mk(4'h1, 8'h01));
    wrd(mk(4'h7, 8'hFF)); put(8'h7E);
    check("strobe count", n_stb, 4);

    cur_req = "R9"; n_stb = 0;
    step(1'b0, 8'h40); sync(); step(1'b0, 8'h7E);
    put(mk(4'h9, 8'hC3) >> 8); step(1'b0, 8'h00); step(1'b0, 8'hFF);
    put(mk(4'h9, 8'hC3) & 16'hFF); step(1'b0, 8'h7E); put(8'h7E);
    check("strobe count", n_stb, 1);

    cur_req = "R3"; n_stb = 0;
    put(8'h40); put(8'h4C); put(8'h40); put(8'h4C); put(8'h44); put(8'h53); put(8'h7E);
    wrd(mk(4'h4, 8'h80)); put(8'h7E);
    put(8'h40); put(8'h4C); put(8'h44); put(8'h00); wrd(mk(4'h5, 8'h11));
    check("strobe count", n_stb, 1);

    cur_req = "R7"; n_stb = 0;
    sync(); put(8'h7E); wrd(mk(4'h6, 8'h22)); wrd(mk(4'h6, 8'h23));
    check("strobes after close", n_stb, 0);

    cur_req = "R5"; n_stb = 0;
    sync(); wrd(mk(4'h2, 8'h44) ^ 16'h0040);
    check("err raised", chk_err, 1);
    wrd(mk(4'h2, 8'h44) | 16'h8000); wrd(mk(4'h2, 8'h44) ^ 16'h4000);
    wrd(mk(4'h2, 8'h44) | 16'h0080); wrd(mk(4'h2, 8'h44));
    put(8'h7E);
    check("strobe count", n_stb, 1);
    check("err sticky", chk_err, 1);

    cur_req = "R8"; n_stb = 0;
    sync(); wrd(mk(4'h5, 8'h10));
    check("default bank", wr_alt_bank, 0);
    wrd(mk(4'hF, 8'h20));
    check("bank write carries old bank", wr_alt_bank, 0);
    wrd(mk(4'h5, 8'h10));
    check("alt bank write", wr_alt_bank, 1);
    put(8'h7E);

    cur_req = "R10";
    sync(); wrd(mk(4'h6, 8'h01));
    check("bank kept across frames", wr_alt_bank, 1);
    cur_req = "R8";
    wrd(mk(4'hF, 8'h30));
    check("bank write carries alt bank", wr_alt_bank, 1);
    wrd(mk(4'h6, 8'h01));
    check("back to default", wr_alt_bank, 0);
    put(8'h7E);
    step(1'b0, 8'h00);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule